// File: doc/BRIEF.md
# Event Time-Stamp Capture Unit

This block records the moment an external event happens, measured against a free-running timer count that arrives on an input port. One of two event sources is chosen by a select bit: a device pin or the output of an on-chip comparator. The chosen level passes through a synchronizer, then through an optional digital noise filter, and then to an edge detector. The edge detector can be set to react to rising or to falling transitions. When a qualifying transition is seen, the current count value is stored in a capture register and a capture flag is raised in the same clock cycle.

Software reaches the capture register over an 8-bit register port. Reading the low byte also copies the high byte into a holding byte, so a later high-byte read returns a value that matches the low byte already read, even if a new capture lands between the two reads. When the surrounding timer uses the capture register as its period limit, captures are suppressed and the register can be written instead: high byte first into the holding byte, then a low-byte write that updates all 16 bits at once. An interrupt request is the flag gated by an enable, and the flag is cleared by a software clear strobe or by an interrupt acknowledge.

All pins are plain level or single-cycle strobe signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure: a register access completes in the cycle its strobe is high, and the block never stalls the bus.

Top module: `evt_stamp_unit`

## Requirements
- R1: With `src_sel_i` = 0 the pin input is the event source, and with `src_sel_i` = 1 the comparator input is; the other input has no effect. A change of `src_sel_i` that changes the selected level counts as a transition and may cause a capture.
- R2: The selected input passes through two synchronizer flops. With the filter off, an input level change first seen at clock edge k produces a capture at edge k+2, so the stored value equals the count present before edge k plus 2.
- R3: With `filt_en_i` = 1 the filtered level follows the synchronized input only after four consecutive samples agree; a pulse lasting fewer than four cycles produces no capture, and a clean change is stamped with the count before edge k plus 6.
- R4: With `edge_rise_i` = 1 only low-to-high transitions capture; with `edge_rise_i` = 0 only high-to-low transitions capture.
- R5: On a capture the count value is written into the capture register and `flag_o` goes high on the same clock edge; a later capture overwrites an unread earlier value.
- R6: `flag_o` is cleared by a one-cycle pulse on `flag_clr_i` or on `irq_ack_i`; if a capture happens in the same cycle, the flag stays set. `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R7: `hi_sel_i` = 0 addresses the low byte and `hi_sel_i` = 1 the high byte. `rdata_o` shows capture bits 7:0 when the low byte is addressed and the holding byte when the high byte is addressed. A low-byte read strobe copies capture bits 15:8 into the holding byte; a high-byte read has no side effect.
- R8: While `top_mode_i` = 1 no capture occurs; a high-byte write loads the holding byte and a low-byte write stores {holding byte, written byte} into the capture register. Writes while `top_mode_i` = 0 leave the capture register unchanged.
- R9: After reset the capture register, the holding byte and the flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running timer count to be stamped |
| pin_evt_i | input | 1 | Event level from the device pin |
| cmp_evt_i | input | 1 | Event level from the comparator |
| src_sel_i | input | 1 | Source select: 0 pin, 1 comparator |
| filt_en_i | input | 1 | Noise filter enable |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| top_mode_i | input | 1 | Capture register serves as timer period limit |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| hi_sel_i | input | 1 | Byte address: 0 low byte, 1 high byte |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte |
| flag_clr_i | input | 1 | Software flag clear strobe |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, that a capture stores the count of the preceding cycle and raises the flag, that the capture register and holding byte do not change without a capture or an access that allows it, that clears take effect when no capture competes, that only the selected polarity triggers, and that the flag never rises in period-limit mode. The exact pipeline latency with and without the filter, rejection of short glitches, the capture caused by switching source, and the torn-read protection across a capture landing between the two byte reads can only be shown by the bench's directed scenarios against its cycle-by-cycle reference model.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  // byte address on the register port
  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;

  // edge polarity encoding on the edge select input
  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/evt_stamp_sync.sv
module evt_stamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic cmp_i,
  input  logic sel_i,
  output logic lvl_o
);
  logic              raw;
  logic [STAGES-1:0] chain;

  assign raw = sel_i ? cmp_i : pin_i;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign lvl_o = chain[STAGES-1];
endmodule

// File: rtl/evt_stamp_filter.sv
module evt_stamp_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic din_i,
  output logic lvl_o
);
  localparam int HIST_W = LEN - 1;

  logic [HIST_W-1:0] hist;
  logic              held;
  logic              agree;

  // current sample plus HIST_W stored samples make LEN agreeing samples
  assign agree = (hist == {HIST_W{din_i}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      held <= 1'b0;
    end else begin
      if (HIST_W > 1) hist <= {hist[HIST_W-2:0], din_i};
      else            hist <= din_i;
      if (agree) held <= din_i;
    end
  end

  assign lvl_o = en_i ? held : din_i;
endmodule

// File: rtl/evt_stamp_edge.sv
module evt_stamp_edge
  import evt_stamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic block_i,
  output logic evt_o
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_i;
  end

  assign evt_o = (lvl_i != prev) && (lvl_i == (rise_i == POL_RISE)) && !block_i;
endmodule

// File: rtl/evt_stamp_regs.sv
module evt_stamp_regs
  import evt_stamp_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_evt_i,
  input  logic             top_mode_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic             hi_sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             flag_clr_i,
  input  logic             irq_ack_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [BUS_W-1:0] temp_o
);
  logic [CNT_W-1:0] cap_q;
  logic [BUS_W-1:0] temp_q;
  logic             flag_q;
  logic             wr_lo, wr_hi, rd_lo;

  assign wr_lo = wr_en_i && top_mode_i && (hi_sel_i == BYTE_LO);
  assign wr_hi = wr_en_i && top_mode_i && (hi_sel_i == BYTE_HI);
  assign rd_lo = rd_en_i && (hi_sel_i == BYTE_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      temp_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt_i)  cap_q <= cnt_i;
      else if (wr_lo) cap_q <= {temp_q, wdata_i};

      if (wr_hi)      temp_q <= wdata_i;
      else if (rd_lo) temp_q <= cap_q[CNT_W-1:BUS_W];

      if (cap_evt_i)                     flag_q <= 1'b1;
      else if (flag_clr_i || irq_ack_i)  flag_q <= 1'b0;
    end
  end

  assign rdata_o = (hi_sel_i == BYTE_HI) ? temp_q : cap_q[BUS_W-1:0];
  assign flag_o  = flag_q;
  assign cap_o   = cap_q;
  assign temp_o  = temp_q;
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit #(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int CNT_W      = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_evt_i,
  input  logic             cmp_evt_i,
  input  logic             src_sel_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             top_mode_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic             hi_sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic             sync_lvl;
  logic             det_lvl;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic [BUS_W-1:0] temp_q;

  evt_stamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_evt_i), .cmp_i(cmp_evt_i),
    .sel_i(src_sel_i), .lvl_o(sync_lvl)
  );

  evt_stamp_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .en_i(filt_en_i), .din_i(sync_lvl), .lvl_o(det_lvl)
  );

  evt_stamp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(det_lvl), .rise_i(edge_rise_i),
    .block_i(top_mode_i), .evt_o(cap_evt)
  );

  evt_stamp_regs #(.BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cap_evt_i(cap_evt),
    .top_mode_i(top_mode_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .hi_sel_i(hi_sel_i), .wdata_i(wdata_i), .flag_clr_i(flag_clr_i),
    .irq_ack_i(irq_ack_i), .rdata_o(rdata_o), .flag_o(flag_o),
    .cap_o(cap_q), .temp_o(temp_q)
  );

  assign irq_o = flag_o && irq_en_i;
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             cap_evt,
  input logic             det_lvl,
  input logic [CNT_W-1:0] cap_q,
  input logic [BUS_W-1:0] temp_q,
  input logic             edge_rise_i,
  input logic             top_mode_i,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic             hi_sel_i,
  input logic             flag_clr_i,
  input logic             irq_ack_i,
  input logic             flag_o
);
  AST_CAP_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (flag_o && cap_q == $past(cnt_i))); // R5

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !(wr_en_i && top_mode_i && !hi_sel_i)) |=> $stable(cap_q)); // R8

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && !wr_en_i) |=> $stable(temp_q)); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr_i || irq_ack_i) && !cap_evt) |=> !flag_o); // R6

  AST_EDGE_POL: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (det_lvl == edge_rise_i)); // R4

  AST_NO_CAP_IN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode_i |=> !$rose(flag_o)); // R8
endmodule

bind evt_stamp_unit evt_stamp_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cap_evt(cap_evt), .det_lvl(det_lvl),
  .cap_q(cap_q), .temp_q(temp_q), .edge_rise_i(edge_rise_i),
  .top_mode_i(top_mode_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
  .hi_sel_i(hi_sel_i), .flag_clr_i(flag_clr_i), .irq_ack_i(irq_ack_i),
  .flag_o(flag_o)
);

// File: tb/evt_stamp_unit_tb_top.sv
`timescale 1ns/1ps
module evt_stamp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0100;
  logic        pin = 0, cmp = 0, src_sel = 0, filt_en = 0, edge_rise = 1, top_mode = 0;
  logic        rd_en = 0, wr_en = 0, hi_sel = 0, flag_clr = 0, irq_en = 0, irq_ack = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        flag, irq;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  evt_stamp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_evt_i(pin), .cmp_evt_i(cmp),
    .src_sel_i(src_sel), .filt_en_i(filt_en), .edge_rise_i(edge_rise),
    .top_mode_i(top_mode), .rd_en_i(rd_en), .wr_en_i(wr_en), .hi_sel_i(hi_sel),
    .wdata_i(wdata), .rdata_o(rdata), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .irq_ack_i(irq_ack), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          sq[$];          // synchronizer contents, newest first
  int          run;            // length of current run of equal synchronized samples
  bit          last_s, m_filt, m_prev, m_flag;
  logic [15:0] m_cap;
  logic [7:0]  m_temp;

  always @(posedge clk) begin
    if (!rst_n) begin
      sq = '{0, 0}; run = 4; last_s = 0; m_filt = 0; m_prev = 0;
      m_flag = 0; m_cap = 0; m_temp = 0;
    end else begin
      bit sel_v, s_pre, det, ev;
      logic [15:0] cap_old;
      logic [7:0]  temp_old;
      sel_v = src_sel ? cmp : pin;
      s_pre = sq[1];
      det = filt_en ? m_filt : s_pre;
      ev = (det != m_prev) && (det == edge_rise) && !top_mode;
      m_prev = det;
      if (s_pre == last_s) run = (run < 8) ? run + 1 : run; else run = 1;
      last_s = s_pre;
      if (run >= 4) m_filt = s_pre;
      sq.push_front(sel_v);
      void'(sq.pop_back());
      cap_old = m_cap; temp_old = m_temp;
      if (ev) m_cap = cnt;
      else if (wr_en && top_mode && !hi_sel) m_cap = {temp_old, wdata};
      if (wr_en && top_mode && hi_sel) m_temp = wdata;
      else if (rd_en && !hi_sel) m_temp = cap_old[15:8];
      if (ev) m_flag = 1;
      else if (flag_clr || irq_ack) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    cnt = cnt + 1;
    if (rst_n && !done) begin
      chk("R5 flag model", {15'd0, flag}, {15'd0, m_flag});
      chk("R6 irq model", {15'd0, irq}, {15'd0, (m_flag & irq_en)});
      chk("R7 rdata model", {8'd0, rdata}, {8'd0, (hi_sel ? m_temp : m_cap[7:0])});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic clr_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo;
    hi_sel = 0; rd_en = 1; #1 lo = rdata;
    step(); rd_en = 0; hi_sel = 1; #1 v = {rdata, lo};
    hi_sel = 0;
  endtask

  task automatic wr8(input logic hi, input logic [7:0] d);
    hi_sel = hi; wdata = d; wr_en = 1; step(); wr_en = 0; hi_sel = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c, v;
    step(3); rst_n = 1; step(2);
    // R9 reset state
    chk("R9 flag", {15'd0, flag}, 16'd0);
    rd16(v); chk("R9 capture", v, 16'h0000);

    // R2 timestamp, filter off, rising
    pin = 1; c = cnt; step(8);
    chk("R5 flag set", {15'd0, flag}, 16'd1);
    rd16(v); chk("R2 stamp no filter", v, c + 16'd2);

    // R4 falling select
    clr_flag(); edge_rise = 0; step(2);
    pin = 0; c = cnt; step(8);
    rd16(v); chk("R4 falling stamp", v, c + 16'd2);
    clr_flag(); pin = 1; step(8);
    chk("R4 rising ignored", {15'd0, flag}, 16'd0);

    // R3 filter: short pulse rejected, clean edge stamped +6
    edge_rise = 1; pin = 0; step(8); clr_flag(); filt_en = 1; step(8);
    pin = 1; step(3); pin = 0; step(10);
    chk("R3 glitch rejected", {15'd0, flag}, 16'd0);
    pin = 1; c = cnt; step(12);
    rd16(v); chk("R3 stamp filtered", v, c + 16'd6);
    filt_en = 0; step(4);

    // R1 source select
    pin = 0; step(8); clr_flag(); src_sel = 1; step(4);
    pin = 1; step(3); pin = 0; step(8);
    chk("R1 pin ignored", {15'd0, flag}, 16'd0);
    cmp = 1; c = cnt; step(8);
    rd16(v); chk("R1 comparator stamp", v, c + 16'd2);
    cmp = 0; step(6); pin = 1; step(6); clr_flag();
    src_sel = 0; step(8);
    chk("R1 switch capture", {15'd0, flag}, 16'd1);

    // R6 interrupt gating and acknowledge
    irq_en = 0; #1 chk("R6 irq gated", {15'd0, irq}, 16'd0);
    irq_en = 1; #1 chk("R6 irq raised", {15'd0, irq}, 16'd1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R6 ack clears", {15'd0, flag}, 16'd0);
    irq_en = 0;

    // R5 overwrite
    pin = 0; step(6); pin = 1; step(6); pin = 0; step(6);
    pin = 1; c = cnt; step(6);
    rd16(v); chk("R5 overwrite", v, c + 16'd2);

    // R7 holding byte protects a split read
    pin = 0; step(6); cnt = 16'h12F0; step(); pin = 1; step(8);
    cnt = 16'h5600;
    hi_sel = 0; rd_en = 1; step(); rd_en = 0;
    pin = 0; step(4); pin = 1; step(8);
    hi_sel = 1; #1 chk("R7 temp kept", {8'd0, rdata}, 16'h0012);
    hi_sel = 0;

    // R8 period-limit mode
    clr_flag(); top_mode = 1; step();
    pin = 0; step(6); pin = 1; step(8);
    chk("R8 no capture", {15'd0, flag}, 16'd0);
    wr8(1, 8'hAB); wr8(0, 8'hCD);
    rd16(v); chk("R8 write commit", v, 16'hABCD);
    top_mode = 0; step(2);
    wr8(1, 8'h11); wr8(0, 8'h22);
    rd16(v); chk("R8 write ignored", v, 16'hABCD);

    step(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule